// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is a single-lane SPI master that moves one word per transaction. While `run` is high and the engine is idle, it starts a word. If the transmitter is on, the word is taken from `tx_data` through a valid/ready handshake. The received word appears on `rx_data` with a `rx_valid` flag, and the consumer clears that flag with `rx_ready`. The serial clock runs at the module clock divided by 2*(divider+1). Word length, polarity, phase sense, bit order and loopback are all configurable.

The idle level of the serial clock has its own bit, separate from the polarity bit. The phase bit has the inverse sense of the usual CPHA: 1 samples on the leading edge, 0 samples on the trailing edge. Each word is framed by its configuration, which is captured at the start of the word, so a change made while a word is shifting takes effect at the next word. `busy` stays high until the last bit has been held for a full half period after the final clock edge. There are two event flags, each a one-cycle pulse: a missing transmit word (underflow) and a received word that overwrites an unread one (overflow).

Top module: `spi_shift_engine`

## Requirements
- R1: While a word shifts, SCLK starts at the latched polarity level `cfg_pol` and toggles exactly 2*N times. Every half period lasts `cfg_div`+1 module clocks.
- R2: The word length is N = `cfg_len_m1`+1. The lengths 2 to 8, 16 and 32 work in both directions, and only bits [N-1:0] are shifted.
- R3: With `cfg_phase`=1, MISO is sampled on each leading edge (the edge leaving the polarity level) and MOSI changes on trailing edges. With `cfg_phase`=0, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: Whenever `busy` is low, SCLK equals `cfg_idle`, independent of `cfg_pol`.
- R5: With `cfg_msb_first`=1, bit N-1 goes first on MOSI and the first received bit lands in `rx_data[N-1]`. With `cfg_msb_first`=0, bit 0 goes first in both directions.
- R6: With `cfg_loop`=1, the receive path samples the engine's own MOSI and ignores MISO, so `rx_data` equals the transmitted word.
- R7: With `tx_off`=1, `tx_ready` stays low, no transmit word is consumed, and MOSI stays 0 for the whole word.
- R8: With `rx_off`=1, the finished word is discarded: `rx_valid` and `rx_data` keep their previous values.
- R9: `busy` rises in the cycle after a word starts and lasts (2N+1)*(`cfg_div`+1) cycles. `tx_ready` is high only while the engine is idle. MOSI is 0 while idle.
- R10: If a word starts with the transmitter on and `tx_valid` low, `tx_underflow` pulses for one cycle as `busy` rises, and the word shifts all zeros.
- R11: If a word finishes while `rx_valid` is high and not being taken, `rx_overflow` pulses for one cycle and the new word replaces the old one.
- R12: All configuration inputs except `cfg_idle` are captured when a word starts. Changing them during the word does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Half-period divider value (half period = value+1 clocks) |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_pol | input | 1 | SCLK level at word start (polarity) |
| cfg_phase | input | 1 | 1: sample on leading edge, 0: sample on trailing edge |
| cfg_idle | input | 1 | SCLK level between words |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_loop | input | 1 | Receive from own MOSI instead of MISO |
| tx_off | input | 1 | Transmitter switched off |
| rx_off | input | 1 | Receiver switched off |
| run | input | 1 | Start words while high and idle |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | Received word not yet taken |
| rx_ready | input | 1 | Consumer takes the received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in progress |
| tx_underflow | output | 1 | One-cycle pulse: word started without transmit data |
| rx_overflow | output | 1 | One-cycle pulse: unread word overwritten |

## Verification
The bench runs a slave model that drives MISO on the shift edges it detects and records MOSI on the sample edges. A design with the phase sense inverted would make that slave read bits one edge off, so both captured words would come out shifted. The bench measures every half period and the busy window at the divider extremes 0 and 3 with 32-bit words. An off-by-one in the divider or a missing final hold half period shows up there as a wrong count. It also changes every configuration input in the middle of a word, so an engine that does not latch its configuration would corrupt that word. Directed runs cover a missing transmit word, an unread receive word, transmitter off, receiver off, and an idle level that differs from the polarity. A design that dropped the overflow pulse or let rx_off overwrite `rx_data` would fail those runs.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int SPI_WMAX = 32;
  localparam int SPI_LW   = $clog2(SPI_WMAX);

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;

  typedef struct packed {
    logic pol;
    logic cpha0;
    logic msb;
    logic loopb;
    logic txoff;
    logic rxoff;
  } word_cfg_t;

  // Effective length in bits; a programmed value of 0 is treated as 2 bits.
  function automatic logic [SPI_LW:0] eff_len(input logic [SPI_LW-1:0] m1);
    return (m1 == '0) ? (SPI_LW+1)'(2) : ({1'b0, m1} + (SPI_LW+1)'(1));
  endfunction

  // Put the word in wire order (bit 0 first on the wire). The mapping is its
  // own inverse, so the same function turns wire order back into a word.
  function automatic logic [SPI_WMAX-1:0] order_word(input logic [SPI_WMAX-1:0] w,
                                                     input logic [SPI_LW:0] n,
                                                     input logic msb);
    logic [SPI_WMAX-1:0] r;
    r = '0;
    for (int i = 0; i < SPI_WMAX; i++) begin
      if (i < int'(n)) r[i] = msb ? w[int'(n) - 1 - i] : w[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  // R1: with a nonzero divider two ticks are never adjacent
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler
  import spi_eng_pkg::*;
#(
  parameter int W  = SPI_WMAX,
  parameter int LW = SPI_LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          bit_in,
  input  logic          finish,
  input  logic [LW:0]   len,
  input  logic          msb,
  input  logic          take,
  output logic [W-1:0]  rx_data,
  output logic          rx_valid,
  output logic          overflow
);
  logic [W-1:0]  acc;
  logic [LW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      idx      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      overflow <= 1'b0;
      if (rx_valid && take) rx_valid <= 1'b0;
      if (clear) begin
        acc <= '0;
        idx <= '0;
      end else if (sample) begin
        acc[idx] <= bit_in;
        idx      <= idx + LW'(1);
      end
      if (finish) begin
        rx_data  <= order_word(acc, len, msb);
        rx_valid <= 1'b1;
        overflow <= rx_valid && !take;
      end
    end
  end

  // R11: an overflow pulse only follows a word that was still unread
  assert_ovf_had_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(rx_valid));
  // R8: a new received word appears only when a finish was signalled
  assert_valid_needs_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(finish));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [SPI_LW-1:0]    cfg_len_m1,
  input  logic                 cfg_pol,
  input  logic                 cfg_phase,
  input  logic                 cfg_idle,
  input  logic                 cfg_msb_first,
  input  logic                 cfg_loop,
  input  logic                 tx_off,
  input  logic                 rx_off,
  input  logic                 run,
  input  logic [SPI_WMAX-1:0]  tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [SPI_WMAX-1:0]  rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 busy,
  output logic                 tx_underflow,
  output logic                 rx_overflow
);
  localparam int W  = SPI_WMAX;
  localparam int LW = SPI_LW;
  localparam int HW = LW + 2;

  eng_state_t       st;
  word_cfg_t        cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [LW:0]      len_q;
  logic [HW-1:0]    half_idx;
  logic [W-1:0]     tx_sr;
  logic             sclk_q, mosi_q, unf_q;

  // Named internal events
  logic          start, unf_evt, half_tick, word_done, edge_evt;
  logic          leading, sample_evt, shift_evt, rx_bit;
  logic [W-1:0]  load_word, ordered;

  assign start     = (st == ST_IDLE) && run && !(tx_off && rx_off);
  assign tx_ready  = start && !tx_off;
  assign unf_evt   = start && !tx_off && !tx_valid;
  assign load_word = (tx_off || !tx_valid) ? '0 : tx_data;
  assign ordered   = order_word(load_word, eff_len(cfg_len_m1), cfg_msb_first);

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(st == ST_SHIFT), .div(div_q), .tick(half_tick)
  );

  assign word_done  = half_tick && (half_idx == {len_q, 1'b0});
  assign edge_evt   = half_tick && !word_done;
  assign leading    = !half_idx[0];
  assign sample_evt = edge_evt && (cfg_q.cpha0 ? leading : !leading);
  assign shift_evt  = edge_evt && (cfg_q.cpha0 ? !leading : leading);
  assign rx_bit     = cfg_q.loopb ? mosi_q : miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cfg_q    <= '0;
      div_q    <= '0;
      len_q    <= (LW+1)'(2);
      half_idx <= '0;
      tx_sr    <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      unf_q <= unf_evt;
      if (st == ST_IDLE) begin
        if (start) begin
          st       <= ST_SHIFT;
          cfg_q    <= '{pol: cfg_pol, cpha0: cfg_phase, msb: cfg_msb_first,
                        loopb: cfg_loop, txoff: tx_off, rxoff: rx_off};
          div_q    <= cfg_div;
          len_q    <= eff_len(cfg_len_m1);
          half_idx <= '0;
          sclk_q   <= cfg_pol;
          if (cfg_phase) begin
            mosi_q <= ordered[0];
            tx_sr  <= ordered >> 1;
          end else begin
            mosi_q <= 1'b0;
            tx_sr  <= ordered;
          end
        end
      end else if (word_done) begin
        st     <= ST_IDLE;
        mosi_q <= 1'b0;
      end else if (edge_evt) begin
        sclk_q   <= ~sclk_q;
        half_idx <= half_idx + HW'(1);
        if (shift_evt) begin
          mosi_q <= tx_sr[0];
          tx_sr  <= tx_sr >> 1;
        end
      end
    end
  end

  spi_rx_assembler #(.W(W), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample_evt), .bit_in(rx_bit),
    .finish(word_done && !cfg_q.rxoff), .len(len_q), .msb(cfg_q.msb), .take(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .overflow(rx_overflow)
  );

  assign busy         = (st == ST_SHIFT);
  assign sclk         = busy ? sclk_q : cfg_idle;
  assign mosi         = mosi_q;
  assign tx_underflow = unf_q;

  // R9: the handshake only opens while no word is running
  assert_ready_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy);
  // R9: the data line rests low between words
  assert_idle_mosi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
  // R7: a word run with the transmitter off keeps MOSI low
  assert_txoff_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_q.txoff) |-> !mosi);
  // R10: an underflow pulse coincides with a word that has just started
  assert_unf_starts_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |-> (busy && $rose(busy)));
  // R1: the serial clock only moves on a divider tick
  assert_sclk_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_tick) |=> $stable(sclk_q));
endmodule

// File: tb/tb_spi_shift_engine.sv
module tb_spi_shift_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] cfg_div = '0;
  logic [4:0]    cfg_len_m1 = 5'd7;
  logic cfg_pol = 0, cfg_phase = 1, cfg_idle = 0, cfg_msb_first = 1, cfg_loop = 0;
  logic tx_off = 0, rx_off = 0, run = 0, tx_valid = 0, rx_ready = 0, miso = 0;
  logic [31:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk, mosi, busy, tx_underflow, rx_overflow;
  logic [31:0] rx_data;

  spi_shift_engine #(.DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len_m1(cfg_len_m1),
    .cfg_pol(cfg_pol), .cfg_phase(cfg_phase), .cfg_idle(cfg_idle),
    .cfg_msb_first(cfg_msb_first), .cfg_loop(cfg_loop), .tx_off(tx_off),
    .rx_off(rx_off), .run(run), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
  );

  int n_checks = 0, n_err = 0;
  bit all_done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction
  function automatic logic wire_bit(logic [31:0] w, int n, bit msb, int i);
    if (i >= n) return 1'b0;
    return msb ? w[n-1-i] : w[i];
  endfunction
  function automatic logic [31:0] from_wire(logic [31:0] cap, int n, bit msb);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[msb ? n-1-i : i] = cap[i];
    return r;
  endfunction

  // Per-word parameters seen by the slave/monitor
  int w_n = 8, w_div = 0;
  bit w_pol = 0, w_cpha0 = 1, w_msb = 1;
  logic [31:0] w_slave = '0;
  // Monitor results
  int m_edges, m_terr, m_cnt, m_ncap, m_sidx, m_bcnt, m_polerr, m_idle_err = 0;
  logic [31:0] m_cap;
  logic prev_sclk = 0, prev_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        m_cnt = 0; m_edges = 0; m_terr = 0; m_ncap = 0; m_cap = '0; m_bcnt = 1;
        m_polerr = (sclk != w_pol) ? 1 : 0;
        if (w_cpha0) begin miso = wire_bit(w_slave, w_n, w_msb, 0); m_sidx = 1; end
        else m_sidx = 0;
      end else if (busy) begin
        m_cnt++; m_bcnt++;
        if (sclk != prev_sclk) begin
          m_edges++;
          if (m_cnt != w_div + 1) m_terr++;
          m_cnt = 0;
          if ((sclk != w_pol) == w_cpha0) begin
            if (m_ncap < 32) m_cap[m_ncap] = mosi;
            m_ncap++;
          end else begin
            miso = wire_bit(w_slave, w_n, w_msb, m_sidx);
            m_sidx++;
          end
        end
      end else if (sclk != cfg_idle) m_idle_err++;
      prev_sclk = sclk;
      prev_busy = busy;
    end
  end

  bit mdl_valid = 0;
  logic [31:0] mdl_data = '0;

  task automatic xfer(input logic [31:0] txw, input bit give, input logic [31:0] slw,
                      input bit scramble, input bit take_after, input string tag);
    int n, guard;
    bit wrx, wtx, wloop, exp_ovf;
    logic [31:0] exp_tx, exp_rx, got_tx;
    logic [DW-1:0] s_div; logic [4:0] s_len; bit s_pol, s_ph, s_msb, s_loop, s_to, s_ro;
    n = int'(cfg_len_m1) + 1;
    w_n = n; w_div = int'(cfg_div); w_pol = cfg_pol; w_cpha0 = cfg_phase;
    w_msb = cfg_msb_first; w_slave = slw;
    wrx = rx_off; wtx = tx_off; wloop = cfg_loop;
    exp_tx = (wtx || !give) ? 32'h0 : (txw & wmask(n));
    exp_rx = wloop ? exp_tx : (slw & wmask(n));
    @(negedge clk);
    tx_data = txw; tx_valid = give; run = 1;
    #1;
    chk(tx_ready == !wtx, {tag, " R9/R7 tx_ready at start"}, tx_ready, !wtx);
    @(negedge clk);
    chk(busy == 1'b1, {tag, " R9 busy rises"}, busy, 1);
    chk(tx_underflow == (!give && !wtx), {tag, " R10 underflow pulse"}, tx_underflow, !give && !wtx);
    run = 0; tx_valid = 0;
    s_div = cfg_div; s_len = cfg_len_m1; s_pol = cfg_pol; s_ph = cfg_phase;
    s_msb = cfg_msb_first; s_loop = cfg_loop; s_to = tx_off; s_ro = rx_off;
    if (scramble) begin
      cfg_div = DW'($urandom_range(0, 7)); cfg_len_m1 = 5'($urandom_range(1, 31));
      cfg_pol = ~cfg_pol; cfg_phase = ~cfg_phase; cfg_msb_first = ~cfg_msb_first;
      cfg_loop = ~cfg_loop; tx_off = ~tx_off; rx_off = ~rx_off;
    end
    exp_ovf = mdl_valid && !wrx;
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, {tag, " R9 word ends (watchdog)"}, guard, 0);
    if (scramble) begin
      cfg_div = s_div; cfg_len_m1 = s_len; cfg_pol = s_pol; cfg_phase = s_ph;
      cfg_msb_first = s_msb; cfg_loop = s_loop; tx_off = s_to; rx_off = s_ro;
    end
    chk(rx_overflow == exp_ovf, {tag, " R11 overflow pulse"}, rx_overflow, exp_ovf);
    chk(m_edges == 2*n, {tag, " R1/R2 edge count"}, m_edges, 2*n);
    chk(m_terr == 0 && m_polerr == 0, {tag, " R1 half period and start level"}, m_terr, 0);
    chk(m_bcnt == (2*n+1)*(w_div+1), {tag, " R9 busy length"}, m_bcnt, (2*n+1)*(w_div+1));
    got_tx = from_wire(m_cap, n, w_msb);
    chk(got_tx == exp_tx, {tag, " R3/R5 MOSI word"}, got_tx, exp_tx);
    if (!wrx) begin mdl_valid = 1; mdl_data = exp_rx; end
    chk(rx_valid == mdl_valid, {tag, " R8 rx_valid"}, rx_valid, mdl_valid);
    chk(rx_data == mdl_data, {tag, " R6/R11 rx_data"}, rx_data, mdl_data);
    if (take_after) begin
      rx_ready = 1; @(negedge clk); rx_ready = 0; mdl_valid = 0;
      chk(rx_valid == 1'b0, {tag, " R11 rx taken"}, rx_valid, 0);
    end
  endtask

  task automatic set_mode(input int mode, input bit msb, input int len, input int div);
    cfg_pol = mode[1]; cfg_idle = mode[1]; cfg_phase = ~mode[0];
    cfg_msb_first = msb; cfg_len_m1 = 5'(len - 1); cfg_div = DW'(div);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!all_done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && sclk == 0 && mosi == 0, "R9 reset idle", {busy, sclk, mosi}, 0);
    chk(rx_valid == 0 && tx_underflow == 0 && rx_overflow == 0, "R11 reset flags",
        {rx_valid, tx_underflow, rx_overflow}, 0);
    chk(tx_ready == 0, "R9 reset tx_ready", tx_ready, 0);

    // All four modes, MSB first, 8 bits
    for (int m = 0; m < 4; m++) begin
      set_mode(m, 1, 8, 1);
      xfer(32'hA5 + 32'(m), 1, 32'h3C ^ 32'(m), 0, 1, "R3 mode");
    end
    // LSB first
    set_mode(0, 0, 8, 0); xfer(32'h81, 1, 32'h14, 0, 1, "R5 lsb");
    set_mode(3, 0, 8, 2); xfer(32'h0F, 1, 32'hC2, 0, 1, "R5 lsb mode3");
    // Lengths 2, 16, 32 and divider extremes
    set_mode(1, 1, 2, 0);  xfer(32'h2, 1, 32'h1, 0, 1, "R2 len2");
    set_mode(2, 0, 16, 3); xfer(32'hBEEF, 1, 32'h1234, 0, 1, "R2 len16");
    set_mode(0, 1, 32, 3); xfer(32'hDEADBEEF, 1, 32'h600DF00D, 0, 1, "R2 len32");
    set_mode(0, 1, 32, 0); xfer(32'h80000001, 1, 32'h7FFFFFFE, 0, 1, "R1 len32 div0");
    // Loopback
    set_mode(1, 1, 8, 1); cfg_loop = 1;
    xfer(32'h5A, 1, 32'hFF, 0, 1, "R6 loopback");
    cfg_loop = 0;
    // Transmitter off, receiver off
    set_mode(0, 1, 8, 1); tx_off = 1;
    xfer(32'hFF, 1, 32'h96, 0, 1, "R7 tx_off");
    tx_off = 0; rx_off = 1;
    xfer(32'h11, 1, 32'h77, 0, 0, "R8 rx_off");
    rx_off = 0;
    // Underflow
    xfer(32'hAB, 0, 32'h42, 0, 1, "R10 underflow");
    // Overflow: two words, first not taken
    xfer(32'h01, 1, 32'h10, 0, 0, "R11 first");
    xfer(32'h02, 1, 32'h20, 0, 1, "R11 overwrite");
    // Idle level independent of polarity
    set_mode(0, 1, 8, 1); cfg_idle = 1;
    @(negedge clk);
    chk(sclk == 1'b1, "R4 idle level", sclk, 1);
    xfer(32'hC3, 1, 32'h3C, 0, 1, "R4 idle high pol low");
    cfg_idle = 0;
    // Mid-word configuration change
    set_mode(2, 1, 16, 2); xfer(32'hCAFE, 1, 32'h0BAD, 1, 1, "R12 scramble");
    set_mode(1, 0, 5, 1);  xfer(32'h15, 1, 32'h0A, 1, 1, "R12 scramble len5");

    // Random words
    for (int k = 0; k < 40; k++) begin
      int li, len;
      li = $urandom_range(0, 8);
      len = (li < 7) ? li + 2 : ((li == 7) ? 16 : 32);
      set_mode($urandom_range(0, 3), 1'($urandom_range(0, 1)), len, $urandom_range(0, 3));
      cfg_loop = 1'($urandom_range(0, 3) == 0);
      xfer($urandom, $urandom_range(0, 7) != 0, $urandom, $urandom_range(0, 5) == 0,
           $urandom_range(0, 3) != 0, "R2/R3/R5 random");
    end
    cfg_loop = 0;
    chk(m_idle_err == 0, "R4 idle level between words", m_idle_err, 0);

    all_done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule